// File: doc/BRIEF.md
# Indirect-Index Cache Tag Lookup Engine

This block is the tag-search engine of a cache whose tags are not tied to fixed slots. A set number chosen by the caller selects a small primary group of associative tag entries. Tags that do not fit there live in a shared overflow pool, and each set keeps a pointer to the first overflow entry that belongs to it. Each overflow entry points to the next one. A lookup compares every way of the primary group at once. If none of them matches and the set owns an overflow chain, the engine follows that chain one entry per cycle. An entry found in the chain is exchanged with the last primary way, so the next access to it hits in the primary group.

Each lookup ends with a one-cycle response. The response gives hit or miss, the index of the matching entry, the search depth and a computed latency. It also gives the set's recency ordering after the lookup and whether the entry had been referenced before. Separate write ports load tag entries, overwrite chain links and set the per-set chain heads. Storage of the data itself, victim selection and writeback belong to other blocks.

Top module: `iic_tag_lookup`

## Requirements
- R1: During and after reset, `reqReady` is 1 and `rspValid` is 0. Every set head holds the null pointer and no entry is valid, so a lookup after reset misses with depth 1.
- R2: An entry matches only when it is valid and both its tag and its address-space ID equal the request. When several primary ways match, the lowest way wins. A primary hit reports index set*ASSOC+way, depth 1 and latency HASH_DELAY+HIT_LAT, and its response appears one cycle after the request is accepted.
- R3: When the primary ways miss and the set's head pointer is null, the lookup ends at once as a miss with depth 1. A miss reports index NTAGS, the null code.
- R4: When the primary ways miss and the head is not null, the chain is searched one entry per cycle. Depth is 1 plus the number of chain entries examined, and the response appears depth cycles after acceptance. A chain that reaches the null pointer without a match gives a miss.
- R5: On a chain hit, the found tag (with its valid flag, ID, referenced bit and pending count) moves into the last primary way, index set*ASSOC+ASSOC-1, and that index is reported. The last way takes over the found entry's chain pointer. The tag displaced from the last way moves into the found chain slot, and that slot keeps its own link.
- R6: Latency is depth*HASH_DELAY+HIT_LAT. Each entry has a pending count that is loaded by a tag write and falls by one every cycle until it reaches 0. On a hit, if the matching entry's count in its compare cycle is larger than the latency, the count is reported instead.
- R7: Each set keeps an ordering of its way numbers. `rspOrder[p*WAY_W +: WAY_W]` is the way at position p, and position 0 is the most recent. A hit moves its way to position 0 and leaves the other ways in their relative order. A miss leaves the ordering unchanged. Out of reset, position p holds way p.
- R8: `rspWasRef` reports the entry's referenced bit as it was before the hit, and is 0 on a miss. A hit sets the bit, a tag write clears it, and the bit travels with the tag in a chain swap.
- R9: Out of reset, overflow entry i (PRIM_N <= i < NTAGS) links to i+1, and the last one links to NTAGS, the null code. A chain that starts at the first overflow index therefore visits every overflow entry in ascending order.
- R10: A request is taken only while `reqReady` is 1. `reqReady` stays 0 from the cycle after acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqReady | output | 1 | Engine idle, request may be taken |
| reqSet | input | SET_W | Hashed set number |
| reqTag | input | TAG_W | Address tag |
| reqAsid | input | ASID_W | Address-space ID |
| rspValid | output | 1 | One-cycle response strobe |
| rspHit | output | 1 | Lookup found a match |
| rspIdx | output | IDX_W | Matching entry index, NTAGS on a miss |
| rspDepth | output | DEPTH_W | Search depth |
| rspLatency | output | LAT_W | Computed access latency |
| rspWasRef | output | 1 | Referenced bit before this hit |
| rspOrder | output | ASSOC*WAY_W | Set recency ordering after the lookup |
| tagWe | input | 1 | Tag entry write strobe |
| tagWrIdx | input | IDX_W | Entry to write |
| tagWrValid | input | 1 | Valid flag to write |
| tagWrTag | input | TAG_W | Tag to write |
| tagWrAsid | input | ASID_W | Address-space ID to write |
| tagWrPend | input | LAT_W | Initial pending count |
| linkWe | input | 1 | Chain link write strobe |
| linkWrIdx | input | IDX_W | Entry whose link is written |
| linkWrPtr | input | IDX_W | New link value |
| headWe | input | 1 | Set head write strobe |
| headWrSet | input | SET_W | Set whose head is written |
| headWrPtr | input | IDX_W | New head pointer |

## Verification
A primary hit, or a miss with a null head, responds in the cycle after acceptance. Every chain entry examined adds exactly one cycle, so the response is due `depth` cycles after the accepting edge. The bench counts falling edges from acceptance until `rspValid` and requires that count to equal the expected depth. It samples every output on the falling edge of that response cycle. The expected pending-count latency is derived in the same way: a tag written one edge before acceptance has lost `depth` counts by its compare cycle.

// File: rtl/iic_pkg.sv
package iic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRIM = 2'd1,
    ST_WALK = 2'd2
  } lookupState_t;

  // strobes from control to datapath, at most one of the terminal ones per cycle
  typedef struct packed {
    logic capture;    // latch a new request
    logic primHit;    // primary group matched
    logic primMiss;   // primary miss, no chain
    logic walkStart;  // primary miss, enter chain
    logic walkStep;   // chain entry missed, follow link
    logic chainHit;   // chain entry matched, swap
    logic walkMiss;   // chain exhausted
  } lookupStrobe_t;

endpackage

// File: rtl/iic_lookup_ctrl.sv
module iic_lookup_ctrl
  import iic_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          primHit,
  input  logic          headNull,
  input  logic          walkMatch,
  input  logic          walkEnd,
  output logic          reqReady,
  output lookupStrobe_t strobe
);

  lookupState_t state, stateNext;

  always_comb begin
    strobe           = '0;
    strobe.capture   = (state == ST_IDLE) && reqValid;
    strobe.primHit   = (state == ST_PRIM) && primHit;
    strobe.primMiss  = (state == ST_PRIM) && !primHit && headNull;
    strobe.walkStart = (state == ST_PRIM) && !primHit && !headNull;
    strobe.chainHit  = (state == ST_WALK) && walkMatch;
    strobe.walkStep  = (state == ST_WALK) && !walkMatch && !walkEnd;
    strobe.walkMiss  = (state == ST_WALK) && !walkMatch && walkEnd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_PRIM;
      ST_PRIM: stateNext = (primHit || headNull) ? ST_IDLE : ST_WALK;
      ST_WALK: if (walkMatch || walkEnd) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);

  // R10
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !reqReady);

  // R3
  null_head_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRIM && headNull) |=> (state != ST_WALK));

endmodule

// File: rtl/iic_lookup_dpath.sv
module iic_lookup_dpath
  import iic_pkg::*;
#(
  parameter  int NUM_SETS   = 4,
  parameter  int ASSOC      = 2,
  parameter  int NUM_LINES  = 4,
  parameter  int TAG_W      = 8,
  parameter  int ASID_W     = 2,
  parameter  int LAT_W      = 8,
  parameter  int HASH_DELAY = 2,
  parameter  int HIT_LAT    = 1,
  localparam int PRIM_N     = NUM_SETS * ASSOC,
  localparam int NTAGS      = PRIM_N + NUM_LINES - 1,
  localparam int IDX_W      = $clog2(NTAGS + 1),
  localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W      = (ASSOC > 1) ? $clog2(ASSOC) : 1,
  localparam int DEPTH_W    = $clog2(NUM_LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lookupStrobe_t          strobe,
  input  logic [SET_W-1:0]       reqSet,
  input  logic [TAG_W-1:0]       reqTag,
  input  logic [ASID_W-1:0]      reqAsid,
  input  logic                   tagWe,
  input  logic [IDX_W-1:0]       tagWrIdx,
  input  logic                   tagWrValid,
  input  logic [TAG_W-1:0]       tagWrTag,
  input  logic [ASID_W-1:0]      tagWrAsid,
  input  logic [LAT_W-1:0]       tagWrPend,
  input  logic                   linkWe,
  input  logic [IDX_W-1:0]       linkWrIdx,
  input  logic [IDX_W-1:0]       linkWrPtr,
  input  logic                   headWe,
  input  logic [SET_W-1:0]       headWrSet,
  input  logic [IDX_W-1:0]       headWrPtr,
  output logic                   primHit,
  output logic                   headNull,
  output logic                   walkMatch,
  output logic                   walkEnd,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [IDX_W-1:0]       rspIdx,
  output logic [DEPTH_W-1:0]     rspDepth,
  output logic [LAT_W-1:0]       rspLatency,
  output logic                   rspWasRef,
  output logic [ASSOC*WAY_W-1:0] rspOrder
);

  localparam logic [IDX_W-1:0] NULL_PTR = IDX_W'(NTAGS);

  // tag store, primary entries first, overflow pool after
  logic              vldA   [NTAGS];
  logic [TAG_W-1:0]  tagA   [NTAGS];
  logic [ASID_W-1:0] asidA  [NTAGS];
  logic              refA   [NTAGS];
  logic [LAT_W-1:0]  pendA  [NTAGS];
  logic [IDX_W-1:0]  chainA [NTAGS];
  logic [IDX_W-1:0]  headA  [NUM_SETS];
  logic [WAY_W-1:0]  ordA   [NUM_SETS][ASSOC];

  // in-flight request
  logic [SET_W-1:0]   curSet;
  logic [TAG_W-1:0]   curTag;
  logic [ASID_W-1:0]  curAsid;
  logic [IDX_W-1:0]   walkPtr;
  logic [DEPTH_W-1:0] depth;

  function automatic logic [LAT_W-1:0] pendDec(input logic [LAT_W-1:0] v);
    return (v != '0) ? v - LAT_W'(1) : '0;
  endfunction

  // primary compare, all ways in parallel
  logic [IDX_W-1:0] wayIdx [ASSOC];
  logic [ASSOC-1:0] wayHit;

  for (genvar w = 0; w < ASSOC; w++) begin : gWay
    assign wayIdx[w] = IDX_W'(curSet) * IDX_W'(ASSOC) + IDX_W'(w);
    assign wayHit[w] = vldA[wayIdx[w]] && (tagA[wayIdx[w]] == curTag) &&
                       (asidA[wayIdx[w]] == curAsid);
  end

  logic [WAY_W-1:0] primWay;
  always_comb begin
    primWay = '0;
    for (int w = ASSOC - 1; w >= 0; w--)
      if (wayHit[w]) primWay = WAY_W'(w);
  end

  assign primHit  = |wayHit;
  assign headNull = (headA[curSet] == NULL_PTR);

  // chain compare, one entry per cycle
  logic walkSafe;
  assign walkSafe  = (walkPtr < NULL_PTR);
  assign walkMatch = walkSafe && vldA[walkPtr] && (tagA[walkPtr] == curTag) &&
                     (asidA[walkPtr] == curAsid);
  assign walkEnd   = !walkSafe || (chainA[walkPtr] == NULL_PTR);

  logic [IDX_W-1:0] lastIdx;
  assign lastIdx = wayIdx[ASSOC-1];

  // hit resolution, latency and recency update
  logic             anyHit, anyDone;
  logic [WAY_W-1:0] hitWay, hitPos;
  logic [IDX_W-1:0] hitIdx, srcIdx;
  logic [LAT_W-1:0] baseLat, finalLat;
  logic [WAY_W-1:0] newOrd [ASSOC];

  always_comb begin
    anyHit   = strobe.primHit | strobe.chainHit;
    anyDone  = anyHit | strobe.primMiss | strobe.walkMiss;
    hitWay   = strobe.chainHit ? WAY_W'(ASSOC - 1) : primWay;
    hitIdx   = strobe.chainHit ? lastIdx : wayIdx[primWay];
    srcIdx   = strobe.chainHit ? walkPtr : hitIdx;
    baseLat  = LAT_W'(depth) * LAT_W'(HASH_DELAY) + LAT_W'(HIT_LAT);
    finalLat = (pendA[srcIdx] > baseLat) ? pendA[srcIdx] : baseLat;
    hitPos   = '0;
    for (int p = 0; p < ASSOC; p++)
      if (ordA[curSet][p] == hitWay) hitPos = WAY_W'(p);
    newOrd[0] = hitWay;
    for (int p = 1; p < ASSOC; p++)
      newOrd[p] = (WAY_W'(p) <= hitPos) ? ordA[curSet][p-1] : ordA[curSet][p];
  end

  // request capture and chain cursor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSet  <= '0;
      curTag  <= '0;
      curAsid <= '0;
      walkPtr <= NULL_PTR;
      depth   <= DEPTH_W'(1);
    end else begin
      if (strobe.capture) begin
        curSet  <= reqSet;
        curTag  <= reqTag;
        curAsid <= reqAsid;
        depth   <= DEPTH_W'(1);
      end
      if (strobe.walkStart) begin
        walkPtr <= headA[curSet];
        depth   <= DEPTH_W'(2);
      end
      if (strobe.walkStep) begin
        walkPtr <= chainA[walkPtr];
        depth   <= depth + DEPTH_W'(1);
      end
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspIdx     <= NULL_PTR;
      rspDepth   <= '0;
      rspLatency <= '0;
      rspWasRef  <= 1'b0;
      rspOrder   <= '0;
    end else begin
      rspValid <= anyDone;
      if (anyDone) begin
        rspHit     <= anyHit;
        rspIdx     <= anyHit ? hitIdx : NULL_PTR;
        rspDepth   <= depth;
        rspLatency <= anyHit ? finalLat : baseLat;
        rspWasRef  <= anyHit && refA[srcIdx];
        for (int p = 0; p < ASSOC; p++)
          rspOrder[p*WAY_W +: WAY_W] <= anyHit ? newOrd[p] : ordA[curSet][p];
      end
    end
  end

  // set heads and recency ordering
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        headA[s] <= NULL_PTR;
        for (int p = 0; p < ASSOC; p++) ordA[s][p] <= WAY_W'(p);
      end
    end else begin
      if (headWe) headA[headWrSet] <= headWrPtr;
      if (anyHit)
        for (int p = 0; p < ASSOC; p++) ordA[curSet][p] <= newOrd[p];
    end
  end

  // tag entries: countdown, writes, reference marking and chain swap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NTAGS; i++) begin
        vldA[i]   <= 1'b0;
        tagA[i]   <= '0;
        asidA[i]  <= '0;
        refA[i]   <= 1'b0;
        pendA[i]  <= '0;
        chainA[i] <= (i >= PRIM_N) ? IDX_W'(i + 1) : NULL_PTR;
      end
    end else begin
      for (int i = 0; i < NTAGS; i++) pendA[i] <= pendDec(pendA[i]);
      if (tagWe) begin
        vldA[tagWrIdx]  <= tagWrValid;
        tagA[tagWrIdx]  <= tagWrTag;
        asidA[tagWrIdx] <= tagWrAsid;
        refA[tagWrIdx]  <= 1'b0;
        pendA[tagWrIdx] <= tagWrPend;
      end
      if (linkWe) chainA[linkWrIdx] <= linkWrPtr;
      if (strobe.primHit) refA[hitIdx] <= 1'b1;
      if (strobe.chainHit) begin
        vldA[lastIdx]   <= vldA[walkPtr];
        tagA[lastIdx]   <= tagA[walkPtr];
        asidA[lastIdx]  <= asidA[walkPtr];
        pendA[lastIdx]  <= pendDec(pendA[walkPtr]);
        refA[lastIdx]   <= 1'b1;
        chainA[lastIdx] <= chainA[walkPtr];
        vldA[walkPtr]   <= vldA[lastIdx];
        tagA[walkPtr]   <= tagA[lastIdx];
        asidA[walkPtr]  <= asidA[lastIdx];
        pendA[walkPtr]  <= pendDec(pendA[lastIdx]);
        refA[walkPtr]   <= refA[lastIdx];
      end
    end
  end

  logic [WAY_W-1:0] rspWay;
  assign rspWay = WAY_W'(rspIdx - IDX_W'(curSet) * IDX_W'(ASSOC));

  // R6
  hit_latency_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |->
      (rspLatency >= LAT_W'(rspDepth) * LAT_W'(HASH_DELAY) + LAT_W'(HIT_LAT)));

  // R3
  miss_idx_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspIdx == NULL_PTR));

  // R5
  chain_hit_last_way_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspDepth > DEPTH_W'(1)) |-> (rspIdx == lastIdx));

  // R7
  mru_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspOrder[WAY_W-1:0] == rspWay));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspDepth >= DEPTH_W'(1) && rspDepth <= DEPTH_W'(NUM_LINES)));

endmodule

// File: rtl/iic_tag_lookup.sv
module iic_tag_lookup
  import iic_pkg::*;
#(
  parameter  int NUM_SETS    = 4,
  parameter  int ASSOC       = 2,
  parameter  int CACHE_BYTES = 64,
  parameter  int BLK_BYTES   = 16,
  parameter  int TAG_W       = 8,
  parameter  int ASID_W      = 2,
  parameter  int LAT_W       = 8,
  parameter  int HASH_DELAY  = 2,
  parameter  int HIT_LAT     = 1,
  localparam int NUM_LINES   = CACHE_BYTES / BLK_BYTES,
  localparam int PRIM_N      = NUM_SETS * ASSOC,
  localparam int NTAGS       = PRIM_N + NUM_LINES - 1,
  localparam int IDX_W       = $clog2(NTAGS + 1),
  localparam int SET_W       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W       = (ASSOC > 1) ? $clog2(ASSOC) : 1,
  localparam int DEPTH_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [SET_W-1:0]       reqSet,
  input  logic [TAG_W-1:0]       reqTag,
  input  logic [ASID_W-1:0]      reqAsid,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [IDX_W-1:0]       rspIdx,
  output logic [DEPTH_W-1:0]     rspDepth,
  output logic [LAT_W-1:0]       rspLatency,
  output logic                   rspWasRef,
  output logic [ASSOC*WAY_W-1:0] rspOrder,
  input  logic                   tagWe,
  input  logic [IDX_W-1:0]       tagWrIdx,
  input  logic                   tagWrValid,
  input  logic [TAG_W-1:0]       tagWrTag,
  input  logic [ASID_W-1:0]      tagWrAsid,
  input  logic [LAT_W-1:0]       tagWrPend,
  input  logic                   linkWe,
  input  logic [IDX_W-1:0]       linkWrIdx,
  input  logic [IDX_W-1:0]       linkWrPtr,
  input  logic                   headWe,
  input  logic [SET_W-1:0]       headWrSet,
  input  logic [IDX_W-1:0]       headWrPtr
);

  lookupStrobe_t strobe;
  logic primHit, headNull, walkMatch, walkEnd;

  iic_lookup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .primHit   (primHit),
    .headNull  (headNull),
    .walkMatch (walkMatch),
    .walkEnd   (walkEnd),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  iic_lookup_dpath #(
    .NUM_SETS   (NUM_SETS),
    .ASSOC      (ASSOC),
    .NUM_LINES  (NUM_LINES),
    .TAG_W      (TAG_W),
    .ASID_W     (ASID_W),
    .LAT_W      (LAT_W),
    .HASH_DELAY (HASH_DELAY),
    .HIT_LAT    (HIT_LAT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqSet     (reqSet),
    .reqTag     (reqTag),
    .reqAsid    (reqAsid),
    .tagWe      (tagWe),
    .tagWrIdx   (tagWrIdx),
    .tagWrValid (tagWrValid),
    .tagWrTag   (tagWrTag),
    .tagWrAsid  (tagWrAsid),
    .tagWrPend  (tagWrPend),
    .linkWe     (linkWe),
    .linkWrIdx  (linkWrIdx),
    .linkWrPtr  (linkWrPtr),
    .headWe     (headWe),
    .headWrSet  (headWrSet),
    .headWrPtr  (headWrPtr),
    .primHit    (primHit),
    .headNull   (headNull),
    .walkMatch  (walkMatch),
    .walkEnd    (walkEnd),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspIdx     (rspIdx),
    .rspDepth   (rspDepth),
    .rspLatency (rspLatency),
    .rspWasRef  (rspWasRef),
    .rspOrder   (rspOrder)
  );

endmodule

// File: tb/sim_iic_tag_lookup.sv
module sim_iic_tag_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int NULLP      = 11;   // 4 sets * 2 ways + 4 lines - 1

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqSet = '0;
  logic [7:0] reqTag = '0;
  logic [1:0] reqAsid = '0;
  logic       rspValid, rspHit, rspWasRef;
  logic [3:0] rspIdx;
  logic [2:0] rspDepth;
  logic [7:0] rspLatency;
  logic [1:0] rspOrder;
  logic       tagWe = 1'b0;
  logic [3:0] tagWrIdx = '0;
  logic       tagWrValid = 1'b0;
  logic [7:0] tagWrTag = '0;
  logic [1:0] tagWrAsid = '0;
  logic [7:0] tagWrPend = '0;
  logic       linkWe = 1'b0;
  logic [3:0] linkWrIdx = '0;
  logic [3:0] linkWrPtr = '0;
  logic       headWe = 1'b0;
  logic [1:0] headWrSet = '0;
  logic [3:0] headWrPtr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iic_tag_lookup u0 (.*);

  int nChecks = 0;
  int nFails  = 0;

  // captured response
  int gHit, gIdx, gDepth, gLat, gRef, gOrd, gCyc;
  bit gBusyBad;

  // bench model of set 0 for the random phase
  bit mVld [2];
  int mTag [2];
  int mAsid[2];
  bit mRef [2];
  int mOrd [2];

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int idx, input int v, input int t, input int a, input int p);
    tagWe = 1'b1; tagWrIdx = 4'(idx); tagWrValid = v[0];
    tagWrTag = 8'(t); tagWrAsid = 2'(a); tagWrPend = 8'(p);
    @(negedge clk);
    tagWe = 1'b0;
  endtask

  task automatic setLink(input int idx, input int ptr);
    linkWe = 1'b1; linkWrIdx = 4'(idx); linkWrPtr = 4'(ptr);
    @(negedge clk);
    linkWe = 1'b0;
  endtask

  task automatic setHead(input int s, input int ptr);
    headWe = 1'b1; headWrSet = 2'(s); headWrPtr = 4'(ptr);
    @(negedge clk);
    headWe = 1'b0;
  endtask

  task automatic lookup(input int s, input int t, input int a);
    reqSet = 2'(s); reqTag = 8'(t); reqAsid = 2'(a); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    gCyc = 0;
    gBusyBad = 1'b0;
    while (!rspValid && gCyc < 20) begin
      if (reqReady) gBusyBad = 1'b1;
      @(negedge clk);
      gCyc++;
    end
    gHit = int'(rspHit); gIdx = int'(rspIdx); gDepth = int'(rspDepth);
    gLat = int'(rspLatency); gRef = int'(rspWasRef); gOrd = int'(rspOrder);
  endtask

  task automatic lookupChk(input string req, input int s, input int t, input int a,
                           input int eHit, input int eIdx, input int eDepth,
                           input int eLat, input int eRef, input int eOrd);
    lookup(s, t, a);
    chk({req, " hit"}, gHit, eHit);
    chk({req, " idx"}, gIdx, eIdx);
    chk({req, " depth"}, gDepth, eDepth);
    chk({req, " latency"}, gLat, eLat);
    chk({req, " response cycle"}, gCyc, eDepth);
    chk({req, " wasRef"}, gRef, eRef);
    chk({req, " order"}, gOrd, eOrd);
    chk("R10 ready low while busy", int'(gBusyBad), 0);
  endtask

  function automatic int packOrd(input int p0, input int p1);
    return p0 | (p1 << 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 ready in reset", int'(reqReady), 1);
    chk("R1 rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);
    chk("R1 rspValid after reset", int'(rspValid), 0);
    // R1/R3: empty set with null head, depth 1 miss
    lookupChk("R3", 0, 5, 0, 0, NULLP, 1, 3, 0, packOrd(0, 1));

    // random phase on set 0: R2 match rules, R7 ordering, R8 referenced bit
    for (int w = 0; w < 2; w++) begin
      mVld[w] = 0; mTag[w] = 0; mAsid[w] = 0; mRef[w] = 0; mOrd[w] = w;
    end
    for (int i = 0; i < 200; i++) begin
      int r, w, t, a, v, hw;
      r = int'($urandom % 10);
      t = int'($urandom % 4);
      a = int'($urandom % 2);
      if (r < 4) begin
        w = int'($urandom % 2);
        v = (($urandom % 4) != 0) ? 1 : 0;
        fill(w, v, t, a, 0);
        mVld[w] = v[0]; mTag[w] = t; mAsid[w] = a; mRef[w] = 0;
      end else begin
        hw = -1;
        for (int k = 1; k >= 0; k--)
          if (mVld[k] && mTag[k] == t && mAsid[k] == a) hw = k;
        if (hw >= 0) begin
          int eRef;
          eRef = int'(mRef[hw]);
          mRef[hw] = 1;
          if (mOrd[0] != hw) begin
            mOrd[1] = mOrd[0];
            mOrd[0] = hw;
          end
          lookupChk("R2 R7 R8 random", 0, t, a, 1, hw, 1, 3, eRef, packOrd(mOrd[0], mOrd[1]));
        end else begin
          lookupChk("R2 R7 random miss", 0, t, a, 0, NULLP, 1, 3, 0, packOrd(mOrd[0], mOrd[1]));
        end
      end
    end

    // chain walks on set 1 using the reset free list (8 -> 9 -> 10 -> null)
    setHead(1, 8);
    fill(8, 1, 'h21, 1, 0);
    fill(9, 1, 'h22, 1, 0);
    fill(10, 1, 'h23, 1, 0);
    fill(2, 1, 'h10, 1, 0);
    fill(3, 1, 'h11, 1, 0);
    lookupChk("R9 R4 full chain miss", 1, 'h40, 1, 0, NULLP, 4, 9, 0, packOrd(0, 1));
    lookupChk("R5 chain hit promote", 1, 'h23, 1, 1, 3, 4, 9, 0, packOrd(1, 0));
    lookupChk("R5 R8 promoted primary hit", 1, 'h23, 1, 1, 3, 1, 3, 1, packOrd(1, 0));
    lookupChk("R5 demoted tag in chain", 1, 'h11, 1, 1, 3, 4, 9, 0, packOrd(1, 0));
    lookupChk("R8 ref follows swap", 1, 'h23, 1, 1, 3, 4, 9, 1, packOrd(1, 0));
    lookupChk("R2 asid mismatch", 1, 'h10, 2, 0, NULLP, 4, 9, 0, packOrd(1, 0));
    lookupChk("R7 way0 to head", 1, 'h10, 1, 1, 2, 1, 3, 0, packOrd(0, 1));
    fill(2, 0, 'h10, 1, 0);
    lookupChk("R2 R7 invalid entry miss", 1, 'h10, 1, 0, NULLP, 4, 9, 0, packOrd(0, 1));
    setLink(8, NULLP);
    lookupChk("R4 short chain miss", 1, 'h22, 1, 0, NULLP, 2, 5, 0, packOrd(0, 1));

    // pending counts: R6
    fill(4, 1, 'h30, 0, 20);
    lookupChk("R6 pending raises latency", 2, 'h30, 0, 1, 4, 1, 19, 0, packOrd(0, 1));
    fill(5, 1, 'h31, 0, 2);
    lookupChk("R6 small pending ignored", 2, 'h31, 0, 1, 5, 1, 3, 0, packOrd(1, 0));
    setHead(3, 9);
    fill(9, 1, 'h50, 0, 30);
    lookupChk("R6 R5 pending on chain hit", 3, 'h50, 0, 1, 7, 2, 28, 0, packOrd(1, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule